// File: doc/BRIEF.md
# Periodic Second Trim Unit

This block sits between a one-second tick source and a seconds counter and nudges the count to make up for crystal error. Software writes a 32-bit setting word that holds an enable flag, a two-bit direction and a match count. While trimming is on, the block counts the ticks that arrive. On every (match+1)-th tick it either drops that tick so the counter loses one second, or marks it as a double step so the counter gains one second. Every other tick goes through unchanged. The correction rate is one second per (match+1) seconds, which is 1e9/(match+1) parts per billion.

The downstream counter adds one on `tick_out` alone and adds two when `tick_dbl` is also high. Both outputs are registered, so a tick shows on the outputs one clock after it arrives. The block does not make the one-second tick itself.

Top module: `sec_trim`

## Requirements
- R1: After reset both outputs are low and no trimming is active, so a tick arriving before any setting write comes out unchanged one clock later (`tick_out`=1, `tick_dbl`=0).
- R2: When enable bit 23 of the setting word is 0, every tick comes out unchanged one clock later, whatever the direction and match fields hold.
- R3: With bit 23 set and direction bits 20:19 equal to 2 (drop), the ticks numbered match+1, 2(match+1), … after the write produce no output pulse at all. All other ticks pass unchanged.
- R4: With bit 23 set and direction bits 20:19 equal to 3 (add), the ticks numbered match+1, 2(match+1), … produce `tick_out`=1 together with `tick_dbl`=1. All other ticks pass with `tick_dbl`=0.
- R5: Direction codes 0 and 1 apply no trimming even when bit 23 is set.
- R6: Every setting write sets the tick count back to zero, so a rewrite in the middle of an interval starts a full new interval with the next tick.
- R7: A match count of 0 trims every tick, and the largest count the parameter allows (all ones) trims every 2^MATCH_W-th tick.
- R8: The match count is taken from bits MATCH_W-1:0 of the word. Bits MATCH_W to 18, bits 22:21 and bits 31:24 have no effect.
- R9: `tick_dbl` is never high without `tick_out`, and neither output is high unless `tick_in` was high on the clock before.
- R10: A tick arriving in the same cycle as a setting write is handled under the old setting. The count still restarts from zero for the ticks that follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_in | input | 1 | One-cycle pulse, once per second |
| cfg_wr | input | 1 | Setting write strobe |
| cfg_data | input | 32 | Setting word: match 18:0, direction 20:19, enable 23 |
| tick_out | output | 1 | Trimmed tick, one clock after tick_in |
| tick_dbl | output | 1 | With tick_out: the counter steps by two |

## Verification
The bench builds the block with MATCH_W = 4, so the match count runs from 0 to 15. At that size every interval length can be swept for both trimming directions, the all-ones match count included, each over two full intervals and with varied gaps between ticks. The narrow field also leaves bits 4 to 18 of the match field unused, so the bench can show they are ignored. The 19-bit default is never reached at full count, because its longest interval needs over half a million ticks.

// File: rtl/sec_trim_pkg.sv
package sec_trim_pkg;

    localparam int CFG_W      = 32;
    localparam int FLD_M_TOP  = 18;
    localparam int FLD_DIR_LO = 19;
    localparam int FLD_ON_BIT = 23;

    typedef enum logic [1:0] {
        TRIM_NONE0 = 2'd0,
        TRIM_NONE1 = 2'd1,
        TRIM_DROP  = 2'd2,
        TRIM_ADD   = 2'd3
    } trim_dir_e;

    function automatic logic dir_trims(input trim_dir_e d);
        return (d == TRIM_DROP) || (d == TRIM_ADD);
    endfunction

endpackage

// File: rtl/sec_trim_cfg.sv
module sec_trim_cfg
    import sec_trim_pkg::*;
#(
    parameter int MATCH_W = 19
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [CFG_W-1:0]   wr_data,
    output logic               active,
    output trim_dir_e          dir,
    output logic [MATCH_W-1:0] match
);
    typedef struct packed {
        logic               on;
        trim_dir_e          dir;
        logic [MATCH_W-1:0] match;
    } cfg_t;

    cfg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.on    = wr_data[FLD_ON_BIT];
            s_d.dir   = trim_dir_e'(wr_data[FLD_DIR_LO +: 2]);
            s_d.match = wr_data[MATCH_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '{on: 1'b0, dir: TRIM_NONE0, match: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign active = s_q.on && dir_trims(s_q.dir);
    assign dir    = s_q.dir;
    assign match  = s_q.match;

endmodule

// File: rtl/sec_trim_interval.sv
module sec_trim_interval #(
    parameter int MATCH_W = 19
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               active,
    input  logic               clear,
    input  logic [MATCH_W-1:0] match,
    output logic               hit,
    output logic [MATCH_W-1:0] cnt
);
    typedef struct packed {
        logic [MATCH_W-1:0] cnt;
    } ivl_t;

    ivl_t s_d, s_q;

    assign hit = active && (s_q.cnt == match);

    always_comb begin
        s_d = s_q;
        if (clear || !active) begin
            s_d.cnt = '0;
        end else if (tick) begin
            s_d.cnt = hit ? '0 : s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt = s_q.cnt;

endmodule

// File: rtl/sec_trim_apply.sv
module sec_trim_apply
    import sec_trim_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      hit,
    input  trim_dir_e dir,
    output logic      tick_out,
    output logic      tick_dbl
);
    typedef struct packed {
        logic pulse;
        logic dbl;
    } out_t;

    out_t s_d, s_q;

    always_comb begin
        s_d.pulse = tick && !(hit && dir == TRIM_DROP);
        s_d.dbl   = tick && hit && (dir == TRIM_ADD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tick_out = s_q.pulse;
    assign tick_dbl = s_q.dbl;

endmodule

// File: rtl/sec_trim.sv
module sec_trim
    import sec_trim_pkg::*;
#(
    parameter int MATCH_W = 19
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_in,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_data,
    output logic        tick_out,
    output logic        tick_dbl
);
    localparam int M_W = (MATCH_W < 1) ? 1 : ((MATCH_W > FLD_M_TOP + 1) ? FLD_M_TOP + 1 : MATCH_W);

    logic           trim_on;
    trim_dir_e      trim_dir;
    logic [M_W-1:0] trim_match;
    logic           ivl_hit;
    logic [M_W-1:0] cnt_q;

    sec_trim_cfg #(.MATCH_W(M_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr),
        .wr_data (cfg_data),
        .active  (trim_on),
        .dir     (trim_dir),
        .match   (trim_match)
    );

    sec_trim_interval #(.MATCH_W(M_W)) u_ivl (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_in),
        .active (trim_on),
        .clear  (cfg_wr),
        .match  (trim_match),
        .hit    (ivl_hit),
        .cnt    (cnt_q)
    );

    sec_trim_apply u_app (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_in),
        .hit      (ivl_hit),
        .dir      (trim_dir),
        .tick_out (tick_out),
        .tick_dbl (tick_dbl)
    );

endmodule

// File: rtl/sec_trim_chk.sv
module sec_trim_chk #(
    parameter int MATCH_W = 19
) (
    input logic               clk,
    input logic               rst,
    input logic               tick_in,
    input logic               cfg_wr,
    input logic [31:0]        cfg_data,
    input logic               tick_out,
    input logic               tick_dbl,
    input logic [MATCH_W-1:0] cnt
);
    logic               sh_act;
    logic [1:0]         sh_dir;
    logic [MATCH_W-1:0] sh_m;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_act <= 1'b0;
            sh_dir <= 2'd0;
            sh_m   <= '0;
        end else if (cfg_wr) begin
            sh_act <= cfg_data[23] & cfg_data[20];
            sh_dir <= cfg_data[20:19];
            sh_m   <= cfg_data[MATCH_W-1:0];
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) $fell(rst) |-> !tick_out && !tick_dbl) // R1
        else $error("AST_RESET_QUIET");
    AST_NO_TRIM_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        tick_in && !sh_act |=> tick_out && !tick_dbl) // R2
        else $error("AST_NO_TRIM_WHEN_OFF");
    AST_DBL_ONLY_ON_ADD: assert property (@(posedge clk) disable iff (rst)
        tick_dbl |-> $past(sh_act && sh_dir == 2'd3)) // R4
        else $error("AST_DBL_ONLY_ON_ADD");
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        sh_act |-> cnt <= sh_m) // R6
        else $error("AST_CNT_IN_RANGE");
    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> cnt == '0) // R6
        else $error("AST_WRITE_CLEARS");
    AST_DBL_WITH_TICK: assert property (@(posedge clk) disable iff (rst)
        tick_dbl |-> tick_out) // R9
        else $error("AST_DBL_WITH_TICK");
    AST_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (rst)
        tick_out |-> $past(tick_in)) // R9
        else $error("AST_OUT_NEEDS_IN");

endmodule

bind sec_trim sec_trim_chk #(.MATCH_W(M_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_in  (tick_in),
    .cfg_wr   (cfg_wr),
    .cfg_data (cfg_data),
    .tick_out (tick_out),
    .tick_dbl (tick_dbl),
    .cnt      (cnt_q)
);

// File: tb/sec_trim_test.sv
module sec_trim_test;
    localparam int MW = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_in = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_data = '0;
    logic        tick_out;
    logic        tick_dbl;

    int n_chk = 0;
    int n_bad = 0;

    // bench-side model of the setting
    logic     m_act = 1'b0;
    logic [1:0] m_dir = 2'd0;
    int       m_len = 1;
    int       m_k = 0;

    always #2 clk = ~clk;

    sec_trim #(.MATCH_W(MW)) uut (
        .clk(clk), .rst(rst), .tick_in(tick_in), .cfg_wr(cfg_wr),
        .cfg_data(cfg_data), .tick_out(tick_out), .tick_dbl(tick_dbl)
    );

    function automatic logic [31:0] word(input logic on, input logic [1:0] d, input int m);
        return (32'(on) << 23) | (32'(d) << 19) | (32'(m) & 32'h7FFFF);
    endfunction

    task automatic compare(input string req, input logic [1:0] exp);
        n_chk++;
        if ({tick_out, tick_dbl} !== exp) begin
            n_bad++;
            $display("FAIL %s: {tick_out,tick_dbl} = %b, expected %b", req, {tick_out, tick_dbl}, exp);
        end
    endtask

    task automatic model_step(output logic [1:0] e);
        if (m_act) begin
            m_k++;
            if (m_k == m_len) begin
                m_k = 0;
                e = (m_dir == 2'd2) ? 2'b00 : 2'b11;
            end else begin
                e = 2'b10;
            end
        end else begin
            e = 2'b10;
        end
    endtask

    task automatic model_write(input logic [31:0] w);
        m_act = w[23] && w[20];
        m_dir = w[20:19];
        m_len = int'(w[MW-1:0]) + 1;
        m_k   = 0;
    endtask

    task automatic write_cfg(input logic [31:0] w);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_data = w;
        @(negedge clk);
        cfg_wr = 1'b0;
        model_write(w);
        compare("R9 idle after write", 2'b00);
    endtask

    task automatic tick(input string req, input int gap);
        logic [1:0] e;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            compare("R9 idle gap", 2'b00);
        end
        @(negedge clk);
        tick_in = 1'b1;
        model_step(e);
        @(negedge clk);
        tick_in = 1'b0;
        compare(req, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        compare("R1 reset outputs", 2'b00);
        tick("R1 tick before any write", 0);
        tick("R1 tick before any write", 1);

        // R2: enable off, fields loaded with trimming values
        write_cfg(word(1'b0, 2'd2, 0));
        for (int i = 0; i < 4; i++) tick("R2 enable off", i % 2);
        write_cfg(word(1'b0, 2'd3, 1));
        for (int i = 0; i < 4; i++) tick("R2 enable off", 0);

        // R5: direction codes 0 and 1
        for (int d = 0; d < 2; d++) begin
            write_cfg(word(1'b1, 2'(d), 0));
            for (int i = 0; i < 4; i++) tick("R5 no-trim direction", i % 3);
        end

        // R3/R4/R7: sweep every match count for both directions
        for (int d = 2; d < 4; d++) begin
            for (int m = 0; m < (1 << MW); m++) begin
                write_cfg(word(1'b1, 2'(d), m));
                for (int i = 0; i < 2 * (m + 1) + 1; i++) begin
                    if (m == 0 || m == (1 << MW) - 1)
                        tick((d == 2) ? "R7 R3 drop edge count" : "R7 R4 add edge count", i % 3);
                    else
                        tick((d == 2) ? "R3 drop sweep" : "R4 add sweep", i % 3);
                end
            end
        end

        // R6: rewrite mid-interval restarts the count
        write_cfg(word(1'b1, 2'd2, 3));
        tick("R6 before rewrite", 0);
        tick("R6 before rewrite", 0);
        write_cfg(word(1'b1, 2'd2, 3));
        for (int i = 0; i < 5; i++) tick("R6 after rewrite", 0);

        // R8: unused and out-of-width bits ignored (match field 0x12 -> 2)
        write_cfg(word(1'b1, 2'd3, 32'h12) | 32'hFF60_0000);
        for (int i = 0; i < 7; i++) tick("R8 ignored bits", i % 2);
        write_cfg(word(1'b0, 2'd2, 0) | 32'hFF60_0000);
        for (int i = 0; i < 3; i++) tick("R8 ignored bits enable off", 0);

        // R10: tick coincident with write uses old setting
        write_cfg(word(1'b1, 2'd2, 0));
        tick("R10 old setting drops all", 0);
        begin
            logic [1:0] e;
            @(negedge clk);
            tick_in = 1'b1;
            cfg_wr = 1'b1;
            cfg_data = word(1'b1, 2'd3, 1);
            model_step(e);
            @(negedge clk);
            tick_in = 1'b0;
            cfg_wr = 1'b0;
            model_write(word(1'b1, 2'd3, 1));
            compare("R10 coincident tick", e);
        end
        for (int i = 0; i < 4; i++) tick("R10 count restarted", 0);

        @(negedge clk);
        compare("R9 final idle", 2'b00);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule